// File: doc/BRIEF.md
# Serial Engine DMA Channel Register Front End

This block is the software-facing control point for one direction of a serial engine's DMA path. Over a plain 32-bit register bus, software loads a 64-bit buffer address as two words, an optional attribute word and a byte length. Writing the length starts the transfer. The block then issues a one-cycle start pulse carrying the latched address, length and end-of-transfer flag to a separate transfer engine. It keeps that request stable while the engine works, and takes back a done strobe with the byte count, or a bus-error strobe.

Completion and failure events become sticky status bits, which software clears by writing 1s to them. Each status bit has a mask bit. The mask can be written whole, or changed atomically through a set alias and a clear alias, so code that owns one bit never has to read, modify and write the whole mask. A single interrupt line is high whenever a pending status bit is also enabled. The same RTL serves both directions: a parameter selects whether the attribute register holds a real end-of-transfer flag (transmit) or is fixed at zero (receive).

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset, every register reads zero, and `irq`, `xfer_start` and `xfer_eot` are low.
- R2: The address low word (offset 0x00), address high word (0x04), length (0x0C), status (0x10), enable (0x18) and transferred count (0x24) read back through `reg_rdata` in the cycle after `reg_rd_en` is sampled. Any unmapped offset reads zero.
- R3: With HAS_EOT=1, the attribute register (0x08) keeps only bit 0, the end-of-transfer flag. With HAS_EOT=0, it always reads zero and `xfer_eot` stays low.
- R4: A length write whose low LEN_W bits are nonzero, made while idle, raises `xfer_start` for exactly the following cycle. In that cycle `xfer_addr` = {high, low}, `xfer_len` is the written length and `xfer_eot` is the attribute flag. The channel is then busy.
- R5: A length write of zero, or any length write while busy, produces no start pulse, leaves the length register unchanged and sets no status.
- R6: While busy, `xfer_addr`, `xfer_len` and `xfer_eot` hold their launch values even if the address or attribute registers are rewritten.
- R7: A write to 0x18 replaces the 3-bit enable. A write to 0x1C ORs the written bits into it. A write to 0x20 clears the written bits. Reads of 0x18, 0x1C and 0x20 all return the current enable.
- R8: `xfer_done` while busy (and without `xfer_err`) stores `xfer_count` in the count register, sets status bit 0 (done), also sets bit 1 (end-of-transfer) if the launched flag was 1, and returns the channel to idle.
- R9: `xfer_err` while busy sets status bit 2 and returns the channel to idle. It takes priority over a simultaneous `xfer_done`, so no done status is set and the count register is unchanged.
- R10: `xfer_done` or `xfer_err` while idle has no effect on status or the count register.
- R11: Writing to 0x14 clears each status bit written as 1, so all 1s clears everything. If an event sets a bit in the same cycle that bit is being cleared, the bit stays set.
- R12: `irq` is registered and equals the OR of (status AND enable) as updated at the same clock edge that changes either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid the cycle after the read strobe |
| xfer_start | output | 1 | One-cycle launch pulse to the transfer engine |
| xfer_addr | output | 2*DW | Latched buffer address |
| xfer_len | output | LEN_W | Latched byte length |
| xfer_eot | output | 1 | Latched end-of-transfer attribute |
| xfer_done | input | 1 | Transfer completed strobe |
| xfer_err | input | 1 | Bus error strobe |
| xfer_count | input | LEN_W | Bytes moved, valid with `xfer_done` |
| irq | output | 1 | Interrupt request |

## Verification
Every result in this block is registered one stage behind the clock edge that samples its cause. The start pulse, the launched address, status bits, count capture, the enable update and `irq` all appear in the cycle after the write or engine strobe is taken, and read data appears in the cycle after the read strobe. The bench drives each stimulus for one cycle from the falling edge and samples results on the next falling edge, exactly one rising edge later. It samples once more a cycle after that wherever a pulse must have dropped. Same-cycle collisions, such as a clear together with an event, or error together with done, are driven within a single cycle so the priority outcome is observed directly.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  // Register byte offsets; the offsets of the launch-related words are fixed by software
  localparam int OFS_PTR_LO  = 'h00;
  localparam int OFS_PTR_HI  = 'h04;
  localparam int OFS_ATTR    = 'h08;
  localparam int OFS_LEN     = 'h0C;
  localparam int OFS_STAT    = 'h10;
  localparam int OFS_STATCLR = 'h14;
  localparam int OFS_EN      = 'h18;
  localparam int OFS_EN_SET  = 'h1C;
  localparam int OFS_EN_CLR  = 'h20;
  localparam int OFS_CNT     = 'h24;

  // Event bit positions in status and enable
  localparam int EVT_W     = 3;
  localparam int BIT_DONE  = 0;
  localparam int BIT_EOT   = 1;
  localparam int BIT_ERR   = 2;
endpackage

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int LEN_W   = 24,
  parameter bit HAS_EOT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             len_accept,
  output logic [2*DW-1:0]  ptr_q,
  output logic             eot_flag_q,
  output logic [LEN_W-1:0] len_q
);
  import dma_chan_pkg::*;

  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      len_q <= '0;
    end else begin
      if (wr_en && addr == AW'(OFS_PTR_LO)) lo_q <= wdata;
      if (wr_en && addr == AW'(OFS_PTR_HI)) hi_q <= wdata;
      if (len_accept) len_q <= wdata[LEN_W-1:0];
    end
  end

  assign ptr_q = {hi_q, lo_q};

  generate
    if (HAS_EOT) begin : g_tx_attr
      logic eot_r;
      always_ff @(posedge clk) begin
        if (rst) eot_r <= 1'b0;
        else if (wr_en && addr == AW'(OFS_ATTR)) eot_r <= wdata[0];
      end
      assign eot_flag_q = eot_r;
    end else begin : g_rx_attr
      assign eot_flag_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_chan_launch.sv
module dma_chan_launch #(
  parameter int DW    = 32,
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_hit,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic [2*DW-1:0]  ptr,
  input  logic             eot_flag,
  input  logic             done_in,
  input  logic             err_in,
  input  logic [LEN_W-1:0] count_in,
  output logic             accept,
  output logic             busy_q,
  output logic             start_q,
  output logic [2*DW-1:0]  addr_q,
  output logic [LEN_W-1:0] xlen_q,
  output logic             xeot_q,
  output logic [LEN_W-1:0] cnt_q,
  output logic             fin_done,
  output logic             fin_err
);
  assign accept   = len_hit && (len_wdata != '0) && !busy_q;
  assign fin_err  = busy_q && err_in;
  assign fin_done = busy_q && done_in && !err_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      addr_q  <= '0;
      xlen_q  <= '0;
      xeot_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        addr_q <= ptr;
        xlen_q <= len_wdata;
        xeot_q <= eot_flag;
      end else if (fin_err || fin_done) begin
        busy_q <= 1'b0;
      end
      if (fin_done) cnt_q <= count_in;
    end
  end
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq #(
  parameter int AW = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    addr,
  input  logic [dma_chan_pkg::EVT_W-1:0]   wbits,
  input  logic                             evt_done,
  input  logic                             evt_eot,
  input  logic                             evt_err,
  output logic [dma_chan_pkg::EVT_W-1:0]   en_q,
  output logic [dma_chan_pkg::EVT_W-1:0]   pend_q,
  output logic                             irq_q
);
  import dma_chan_pkg::*;

  logic [EVT_W-1:0] en_d, pend_d, set_mask, clr_mask;

  always_comb begin
    en_d = en_q;
    if (wr_en) begin
      if (addr == AW'(OFS_EN))     en_d = wbits;
      if (addr == AW'(OFS_EN_SET)) en_d = en_q | wbits;
      if (addr == AW'(OFS_EN_CLR)) en_d = en_q & ~wbits;
    end
  end

  always_comb begin
    set_mask           = '0;
    set_mask[BIT_DONE] = evt_done;
    set_mask[BIT_EOT]  = evt_eot;
    set_mask[BIT_ERR]  = evt_err;
    clr_mask = (wr_en && addr == AW'(OFS_STATCLR)) ? wbits : '0;
    pend_d   = (pend_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= |(pend_d & en_d);
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int LEN_W   = 24,
  parameter bit HAS_EOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              xfer_start,
  output logic [2*DW-1:0]   xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_eot,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic [LEN_W-1:0]  xfer_count,
  output logic              irq
);
  import dma_chan_pkg::*;

  localparam int PTR_W = 2 * DW;

  logic [PTR_W-1:0] ptr_q;
  logic             eot_flag_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             len_hit, accept, busy, fin_done, fin_err;
  logic [EVT_W-1:0] irq_en, pend;

  assign len_hit = reg_wr_en && reg_addr == AW'(OFS_LEN);

  dma_chan_regfile #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .HAS_EOT(HAS_EOT)) u_rf (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .len_accept(accept), .ptr_q(ptr_q), .eot_flag_q(eot_flag_q), .len_q(len_q)
  );

  dma_chan_launch #(.DW(DW), .LEN_W(LEN_W)) u_launch (
    .clk(clk), .rst(rst), .len_hit(len_hit), .len_wdata(reg_wdata[LEN_W-1:0]),
    .ptr(ptr_q), .eot_flag(eot_flag_q), .done_in(xfer_done), .err_in(xfer_err),
    .count_in(xfer_count), .accept(accept), .busy_q(busy), .start_q(xfer_start),
    .addr_q(xfer_addr), .xlen_q(xfer_len), .xeot_q(xfer_eot), .cnt_q(cnt_q),
    .fin_done(fin_done), .fin_err(fin_err)
  );

  dma_chan_irq #(.AW(AW)) u_irq (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wbits(reg_wdata[EVT_W-1:0]), .evt_done(fin_done),
    .evt_eot(fin_done && xfer_eot), .evt_err(fin_err),
    .en_q(irq_en), .pend_q(pend), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      case (reg_addr)
        AW'(OFS_PTR_LO): reg_rdata <= ptr_q[DW-1:0];
        AW'(OFS_PTR_HI): reg_rdata <= ptr_q[PTR_W-1:DW];
        AW'(OFS_ATTR):   reg_rdata <= DW'(eot_flag_q);
        AW'(OFS_LEN):    reg_rdata <= DW'(len_q);
        AW'(OFS_STAT):   reg_rdata <= DW'(pend);
        AW'(OFS_EN),
        AW'(OFS_EN_SET),
        AW'(OFS_EN_CLR): reg_rdata <= DW'(irq_en);
        AW'(OFS_CNT):    reg_rdata <= DW'(cnt_q);
        default:         reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW    = 8,
  parameter int LEN_W = 24
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           reg_wr_en,
  input logic [AW-1:0]                  reg_addr,
  input logic [LEN_W-1:0]               wdata_lo,
  input logic                           xfer_start,
  input logic                           xfer_err,
  input logic                           busy,
  input logic [dma_chan_pkg::EVT_W-1:0] irq_en,
  input logic [dma_chan_pkg::EVT_W-1:0] pend
);
  import dma_chan_pkg::*;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start); // R4

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(reg_wr_en && reg_addr == AW'(OFS_LEN) && !busy)); // R4

  AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == AW'(OFS_LEN) && wdata_lo == '0) |=> !xfer_start); // R5

  AST_BUSY_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == AW'(OFS_LEN) && busy) |=> !xfer_start); // R5

  AST_EN_SET_ORS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == AW'(OFS_EN_SET)) |=>
      ((irq_en & $past(wdata_lo[EVT_W-1:0])) == $past(wdata_lo[EVT_W-1:0]))); // R7

  AST_EN_CLR_ANDS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == AW'(OFS_EN_CLR)) |=>
      ((irq_en & $past(wdata_lo[EVT_W-1:0])) == '0)); // R7

  AST_ERR_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (busy && xfer_err) |=> pend[BIT_ERR]); // R9

  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy && xfer_err) |=> !busy); // R9
endmodule

bind dma_chan_regs dma_chan_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .wdata_lo(reg_wdata[LEN_W-1:0]), .xfer_start(xfer_start), .xfer_err(xfer_err),
  .busy(busy), .irq_en(irq_en), .pend(pend)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  localparam int AW = 8, DW = 32, LW = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic wr = 1'b0, rd = 1'b0, done = 1'b0, err = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, rdata1;
  logic [LW-1:0] count = '0, xlen, xlen1;
  logic [2*DW-1:0] xaddr, xaddr1;
  logic start, eot, irq, start1, eot1, irq1;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.AW(AW), .DW(DW), .LEN_W(LW), .HAS_EOT(1'b1)) u0 (
    .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .xfer_start(start), .xfer_addr(xaddr),
    .xfer_len(xlen), .xfer_eot(eot), .xfer_done(done), .xfer_err(err),
    .xfer_count(count), .irq(irq));

  dma_chan_regs #(.AW(AW), .DW(DW), .LEN_W(LW), .HAS_EOT(1'b0)) u1 (
    .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata1), .xfer_start(start1), .xfer_addr(xaddr1),
    .xfer_len(xlen1), .xfer_eot(eot1), .xfer_done(done), .xfer_err(err),
    .xfer_count(count), .irq(irq1));

  // {write offset, write data, read offset, expected read}
  localparam logic [79:0] VEC [10] = '{
    {8'h00, 32'h89ABCDEF, 8'h00, 32'h89ABCDEF},
    {8'h04, 32'h01234567, 8'h04, 32'h01234567},
    {8'h08, 32'hFFFFFFFF, 8'h08, 32'h00000001},
    {8'h18, 32'h00000005, 8'h18, 32'h00000005},
    {8'h1C, 32'h00000002, 8'h18, 32'h00000007},
    {8'h20, 32'h00000004, 8'h1C, 32'h00000003},
    {8'h20, 32'h00000001, 8'h20, 32'h00000002},
    {8'h18, 32'hFFFFFFF8, 8'h18, 32'h00000000},
    {8'h30, 32'h00000055, 8'h30, 32'h00000000},
    {8'h1C, 32'h00000007, 8'h18, 32'h00000007}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d1);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0; addr = '0;
    d = rdata; d1 = rdata1;
  endtask

  task automatic finish_xfer(input logic dn, input logic er, input logic [23:0] c);
    done = dn; err = er; count = c;
    @(negedge clk);
    done = 1'b0; err = 1'b0; count = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 start", start, 0);
    chk("R1 eot", eot, 0);
    rreg(8'h00, v, v1); chk("R1 ptr_lo", v, 0);
    rreg(8'h10, v, v1); chk("R1 status", v, 0);
    rreg(8'h24, v, v1); chk("R1 count", v, 0);
    rreg(8'h18, v, v1); chk("R1 enable", v, 0);

    // R2/R3/R7 register table
    for (int i = 0; i < 10; i++) begin
      wreg(VEC[i][79:72], VEC[i][71:40]);
      rreg(VEC[i][39:32], v, v1);
      checks++;
      if (v !== VEC[i][31:0]) begin
        fails++;
        $display("FAIL R2/R7 vec %0d actual=%h expected=%h", i, v, VEC[i][31:0]);
      end
    end
    rreg(8'h0C, v, v1); chk("R2 length reset", v, 0);
    rreg(8'h08, v, v1); chk("R3 rx attr zero", v1, 0);

    // R4 launch
    wreg(8'h0C, 32'h00000040);
    chk("R4 start", start, 1);
    chk("R4 addr", xaddr, 64'h0123456789ABCDEF);
    chk("R4 len", xlen, 24'h40);
    chk("R4 eot", eot, 1);
    chk("R3 rx eot low", eot1, 0);
    @(negedge clk);
    chk("R4 one cycle", start, 0);

    // R5 busy length ignored, R6 held launch values
    wreg(8'h0C, 32'h00000010);
    chk("R5 busy no start", start, 0);
    rreg(8'h0C, v, v1); chk("R5 len unchanged", v, 32'h40);
    wreg(8'h00, 32'h0);
    wreg(8'h08, 32'h0);
    chk("R6 addr held", xaddr, 64'h0123456789ABCDEF);
    chk("R6 eot held", eot, 1);
    chk("R6 len held", xlen, 24'h40);

    // R8 done with end-of-transfer, R12 irq
    finish_xfer(1'b1, 1'b0, 24'h3C);
    chk("R12 irq after done", irq, 1);
    rreg(8'h10, v, v1); chk("R8 status done+eot", v, 32'h3);
    rreg(8'h24, v, v1); chk("R8 count", v, 32'h3C);

    // R11 clears
    wreg(8'h14, 32'h1);
    rreg(8'h10, v, v1); chk("R11 partial clear", v, 32'h2);
    chk("R12 irq still", irq, 1);
    wreg(8'h14, 32'hFFFFFFFF);
    chk("R12 irq drops", irq, 0);
    rreg(8'h10, v, v1); chk("R11 clear all", v, 0);

    // R5 zero length ignored
    wreg(8'h0C, 32'h0);
    chk("R5 zero no start", start, 0);
    rreg(8'h0C, v, v1); chk("R5 zero len unchanged", v, 32'h40);
    rreg(8'h10, v, v1); chk("R5 zero no status", v, 0);

    // R10 events while idle
    finish_xfer(1'b1, 1'b1, 24'h77);
    rreg(8'h10, v, v1); chk("R10 idle status", v, 0);
    rreg(8'h24, v, v1); chk("R10 idle count", v, 32'h3C);

    // R9 error beats done
    wreg(8'h0C, 32'h8);
    chk("R4 relaunch", start, 1);
    chk("R4 eot cleared", eot, 0);
    @(negedge clk);
    finish_xfer(1'b1, 1'b1, 24'h5);
    rreg(8'h10, v, v1); chk("R9 err only", v, 32'h4);
    rreg(8'h24, v, v1); chk("R9 count unchanged", v, 32'h3C);
    chk("R12 irq on err", irq, 1);
    wreg(8'h0C, 32'h4);
    chk("R9 idle after err", start, 1);
    @(negedge clk);
    finish_xfer(1'b1, 1'b0, 24'h4);
    rreg(8'h10, v, v1); chk("R8 done no eot", v, 32'h5);
    rreg(8'h24, v, v1); chk("R8 count 4", v, 32'h4);

    // R11 event beats same-cycle clear
    wreg(8'h14, 32'hFFFFFFFF);
    wreg(8'h0C, 32'h2);
    @(negedge clk);
    done = 1'b1; count = 24'h2; wr = 1'b1; addr = 8'h14; wdata = 32'h1;
    @(negedge clk);
    done = 1'b0; count = '0; wr = 1'b0; addr = '0; wdata = '0;
    rreg(8'h10, v, v1); chk("R11 event wins", v, 32'h1);

    // R12 masking
    wreg(8'h20, 32'h1);
    chk("R12 masked", irq, 0);
    wreg(8'h1C, 32'h1);
    chk("R12 unmasked", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule